// File: doc/BRIEF.md
# Host Physical Address Range Decoder

This block sits at the front of a memory expander endpoint. It turns host physical addresses into device-local addresses. Software programs a 64-bit window base and a 64-bit window size through 32-bit register words. It also sets an interleave width and a chunk size, then commits the decoder with a handshake. After that, each host request is range-checked against the window. The interleave selector bits are cut out of the middle of the offset, and the result is checked against the capacity of the backing memory.

A request that lands is reported with its translated address. A read that misses completes with an error response. A write that misses is dropped quietly and completes as OK. The response appears exactly one clock after the request.

Top module: `hdm_range_decoder`

## Requirements
- R1: After reset every register word reads as zero, the decoder is uncommitted, and `rspValid` is low.
- R2: Register words are 32 bits. Word index 0 is the low half of the base and index 1 its high half. Index 2 is the low half of the size and index 3 its high half. Index 4 is control. Each word reads back the value last written.
- R3: Control fields are: chunk-size code in bits [3:0], interleave-width code in bits [7:4], commit request in bit 8, committed status in bit 9, error status in bit 10. A control write with bit 8 set leaves bit 8 reading 0 and bit 10 reading 0, and sets bit 9 to 1 from the next cycle.
- R4: Bits 9 and 10 cannot be written by software. Writing 1 to them without a commit request does not set them. A control write without a commit request leaves an earlier committed status at 1.
- R5: While the decoder is uncommitted, every request is a miss.
- R6: A host address below the window base is a miss.
- R7: With offset = host address − base, an offset of size − 1 can hit and an offset equal to or above size is a miss.
- R8: The translated address keeps the low (8 + chunk code) offset bits unchanged. Offset bits from position (8 + chunk code + width code) upward are shifted down by the width code and placed above them. The bits in between are discarded.
- R9: A translated address equal to or above the backing capacity (parameter `MEM_BYTES`, default 0x1000_0000) is a miss.
- R10: A read miss gives `rspErr`=1 and `rspHit`=0. A write miss gives `rspErr`=0 and `rspHit`=0. Every hit gives `rspErr`=0 and the translated address on `rspDpa`. `rspDpa` is 0 on a miss.
- R11: `rspValid` is high in exactly the cycle after each cycle with `reqValid` high, including back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register word write strobe |
| cfgAddr | input | 3 | Register word index |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Combinational read data of the word at `cfgAddr` |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write request, 0 = read |
| reqAddr | input | 64 | Host physical address |
| rspValid | output | 1 | Response present (one cycle after the request) |
| rspHit | output | 1 | Request decoded into the backing memory |
| rspErr | output | 1 | Error response for a read miss |
| rspDpa | output | 64 | Translated device-local address |

## Verification
The assertions assume that `reqWrite` matters only in cycles where `reqValid` is high. They also assume that a request and a configuration write in the same cycle are decoded with the configuration that was in place before that edge. The bench drives every input on the falling edge, so each change is settled a half period before the sampling edge. It reprograms the control word only between request bursts, so each expected result depends on a single stable configuration. The chunk and width codes are limited by their 4-bit fields, so the largest shift (38) always stays inside the 64-bit offset.

// File: rtl/hdm_dec_pkg.sv
package hdm_dec_pkg;
  localparam int ADDR_W        = 64;
  localparam int FIELD_W       = 4;
  localparam int SHIFT_W       = $clog2(ADDR_W) + 1;
  localparam int CTRL_GRAN_LSB = 0;
  localparam int CTRL_WAYS_LSB = 4;
  localparam int CTRL_COMMIT   = 8;
  localparam int CTRL_DONE     = 9;
  localparam int CTRL_ERR      = 10;

  // live decoder configuration handed from control to datapath
  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  limit;
    logic [FIELD_W-1:0] gran;
    logic [FIELD_W-1:0] ways;
    logic               committed;
  } decCfg_t;

  // per-cycle request strobes
  typedef struct packed {
    logic fire;
    logic isWrite;
  } reqStb_t;
endpackage

// File: rtl/hdm_dec_ctrl.sv
module hdm_dec_ctrl
  import hdm_dec_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  output decCfg_t           cfg,
  output reqStb_t           stb
);
  localparam int WORDS    = ADDR_W / WORD_W;
  localparam int BASE_IDX = 0;
  localparam int SIZE_IDX = WORDS;
  localparam int CTRL_IDX = 2 * WORDS;

  logic [ADDR_W-1:0]  baseR, sizeR;
  logic [FIELD_W-1:0] granR, waysR;
  logic               committedR, errR;
  logic               ctrlHit;
  logic [WORD_W-1:0]  ctrlView;

  assign ctrlHit = cfgWrEn && (cfgAddr == IDX_W'(CTRL_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseR      <= '0;
      sizeR      <= '0;
      granR      <= '0;
      waysR      <= '0;
      committedR <= 1'b0;
      errR       <= 1'b0;
    end else if (cfgWrEn) begin
      for (int i = 0; i < WORDS; i++) begin
        if (cfgAddr == IDX_W'(BASE_IDX + i)) baseR[i*WORD_W +: WORD_W] <= cfgWrData;
        if (cfgAddr == IDX_W'(SIZE_IDX + i)) sizeR[i*WORD_W +: WORD_W] <= cfgWrData;
      end
      if (ctrlHit) begin
        granR <= cfgWrData[CTRL_GRAN_LSB +: FIELD_W];
        waysR <= cfgWrData[CTRL_WAYS_LSB +: FIELD_W];
        // commit handshake: request self-clears, error clears, status sets
        if (cfgWrData[CTRL_COMMIT]) begin
          errR       <= 1'b0;
          committedR <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[CTRL_GRAN_LSB +: FIELD_W] = granR;
    ctrlView[CTRL_WAYS_LSB +: FIELD_W] = waysR;
    ctrlView[CTRL_DONE] = committedR;
    ctrlView[CTRL_ERR]  = errR;
  end

  always_comb begin
    cfgRdData = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (cfgAddr == IDX_W'(BASE_IDX + i)) cfgRdData = baseR[i*WORD_W +: WORD_W];
      if (cfgAddr == IDX_W'(SIZE_IDX + i)) cfgRdData = sizeR[i*WORD_W +: WORD_W];
    end
    if (cfgAddr == IDX_W'(CTRL_IDX)) cfgRdData = ctrlView;
  end

  assign cfg.base      = baseR;
  assign cfg.limit     = sizeR;
  assign cfg.gran      = granR;
  assign cfg.ways      = waysR;
  assign cfg.committed = committedR;
  assign stb.fire      = reqValid;
  assign stb.isWrite   = reqWrite;

  // R3: a commit request yields committed status with error clear
  a_r3_commit_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlHit && cfgWrData[CTRL_COMMIT]) |=> (cfg.committed && !errR));

  // R4: committed status never falls back without reset
  a_r4_committed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.committed |=> cfg.committed);

  // R4: committed status only rises on a commit request
  a_r4_commit_only_by_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrlHit && cfgWrData[CTRL_COMMIT]) && !cfg.committed |=> !cfg.committed);
endmodule

// File: rtl/hdm_dec_xlate.sv
module hdm_dec_xlate
  import hdm_dec_pkg::*;
#(
  parameter int                GRAN_BASE = 8,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 64'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  decCfg_t           cfg,
  input  reqStb_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspDpa
);
  logic [ADDR_W-1:0]  offset, keepMask, dpa;
  logic [SHIFT_W-1:0] keepW, dropW;
  logic               belowBase, pastEnd, memOk, hit;

  assign belowBase = reqAddr < cfg.base;
  assign offset    = reqAddr - cfg.base;
  assign pastEnd   = offset >= cfg.limit;
  assign keepW     = SHIFT_W'(GRAN_BASE) + SHIFT_W'(cfg.gran);
  assign dropW     = keepW + SHIFT_W'(cfg.ways);
  assign keepMask  = (ADDR_W'(1) << keepW) - ADDR_W'(1);
  assign dpa       = (offset & keepMask) | ((offset >> dropW) << keepW);

  generate
    if (MEM_BYTES == '0) begin : g_unbounded
      assign memOk = 1'b1;
    end else begin : g_bounded
      assign memOk = dpa < MEM_BYTES;
      // R9: a hit never points beyond backing capacity
      a_r9_dpa_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rspHit |-> (rspDpa < MEM_BYTES));
    end
  endgenerate

  assign hit = cfg.committed && !belowBase && !pastEnd && memOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
      rspDpa   <= '0;
    end else begin
      rspValid <= stb.fire;
      rspHit   <= stb.fire && hit;
      rspErr   <= stb.fire && !stb.isWrite && !hit;
      rspDpa   <= (stb.fire && hit) ? dpa : '0;
    end
  end

  // R5: nothing hits before commit
  a_r5_uncommitted_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.fire && !cfg.committed) |=> !rspHit);

  // R10: writes never report an error
  a_r10_write_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.fire && stb.isWrite) |=> !rspErr);

  // R10: hit and error are exclusive and only with a response
  a_r10_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (rspHit || rspErr) |-> (rspValid && !(rspHit && rspErr)));

  // R11: one response per request, one cycle later
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    stb.fire |=> rspValid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.fire |=> !rspValid);
endmodule

// File: rtl/hdm_range_decoder.sv
module hdm_range_decoder
  import hdm_dec_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                IDX_W     = 3,
  parameter int                GRAN_BASE = 8,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 64'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspDpa
);
  decCfg_t cfg;
  reqStb_t stb;

  hdm_dec_ctrl #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .cfg(cfg), .stb(stb)
  );

  hdm_dec_xlate #(.GRAN_BASE(GRAN_BASE), .MEM_BYTES(MEM_BYTES)) u_xlate (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .stb(stb), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspErr(rspErr), .rspDpa(rspDpa)
  );
endmodule

// File: tb/hdm_range_decoder_tb.sv
module hdm_range_decoder_tb;
  localparam logic [63:0] MEM = 64'h1000_0000;
  localparam logic [63:0] B   = 64'h1_2000_0000;

  logic        clk = 0, rst_n = 0;
  logic        cfgWrEn = 0;
  logic [2:0]  cfgAddr = 0;
  logic [31:0] cfgWrData = 0, cfgRdData;
  logic        reqValid = 0, reqWrite = 0;
  logic [63:0] reqAddr = 0, rspDpa;
  logic        rspValid, rspHit, rspErr;

  hdm_range_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspErr(rspErr), .rspDpa(rspDpa)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycle = 0;
  always @(posedge clk) cycle++;

  typedef struct {
    logic        hit;
    logic        err;
    logic [63:0] dpa;
    int          cyc;
    string       req;
  } exp_t;
  exp_t q[$];

  // bench-side view of the programmed configuration
  logic [63:0] mBase = 0, mSize = 0;
  int          mGran = 0, mWays = 0;
  logic        mCommitted = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(int idx, logic [31:0] d);
    @(negedge clk);
    reqValid = 0; cfgWrEn = 1; cfgAddr = 3'(idx); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    case (idx)
      0: mBase[31:0]  = d;
      1: mBase[63:32] = d;
      2: mSize[31:0]  = d;
      3: mSize[63:32] = d;
      4: begin
        mGran = int'(d[3:0]); mWays = int'(d[7:4]);
        if (d[8]) mCommitted = 1;
      end
      default: ;
    endcase
  endtask

  task automatic cfgCheck(int idx, logic [31:0] exp, string req);
    @(negedge clk);
    reqValid = 0; cfgAddr = 3'(idx);
    #1 chk(req, 64'(cfgRdData), 64'(exp));
  endtask

  task automatic sendExp(logic wr, logic [63:0] a, logic h, logic e, logic [63:0] d, string req);
    exp_t it;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a;
    it.hit = h; it.err = e; it.dpa = d; it.cyc = cycle; it.req = req;
    q.push_back(it);
  endtask

  // expectation built from R5-R10
  task automatic sendModel(logic wr, logic [63:0] a, string req);
    logic [63:0] off, d;
    logic h;
    int kw;
    h = 0; d = 0;
    if (mCommitted && a >= mBase && (a - mBase) < mSize) begin
      off = a - mBase;
      kw  = 8 + mGran;
      d   = (off & ((64'd1 << kw) - 64'd1)) | ((off >> (kw + mWays)) << kw);
      h   = d < MEM;
      if (!h) d = 0;
    end
    sendExp(wr, a, h, !wr && !h, d, req);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    reqValid = 0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rspValid) begin
        if (q.size() == 0) begin
          chk("R11 unexpected response", 64'(rspValid), 64'd0);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk({it.req, " R11 latency"}, 64'(cycle), 64'(it.cyc + 1));
          chk({it.req, " hit"}, 64'(rspHit), 64'(it.hit));
          chk({it.req, " err"}, 64'(rspErr), 64'(it.err));
          chk({it.req, " dpa"}, rspDpa, it.dpa);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rspValid in reset", 64'(rspValid), 64'd0);
    rst_n = 1;
    for (int i = 0; i < 5; i++) cfgCheck(i, 32'h0, "R1 reset register");
    @(negedge clk);
    chk("R1 rspValid after reset", 64'(rspValid), 64'd0);

    // R4: status bits not writable
    cfgWrite(4, 32'h0000_0613);
    cfgCheck(4, 32'h0000_0013, "R4 status write ignored");

    // R5: uncommitted decoder misses everything
    sendExp(0, 64'h0, 0, 1, 0, "R5 read before commit");
    sendExp(1, 64'h0, 0, 0, 0, "R5 write before commit");
    idle(2);

    // R2: program window
    cfgWrite(0, 32'h2000_0000);
    cfgWrite(1, 32'h0000_0001);
    cfgWrite(2, 32'h2000_0000);
    cfgWrite(3, 32'h0000_0000);
    cfgCheck(0, 32'h2000_0000, "R2 base low");
    cfgCheck(1, 32'h0000_0001, "R2 base high");
    cfgCheck(2, 32'h2000_0000, "R2 size low");
    cfgCheck(3, 32'h0000_0000, "R2 size high");
    sendExp(0, B, 0, 1, 0, "R5 read still uncommitted");
    idle(1);

    // R3: commit with width 1, chunk 0
    cfgWrite(4, 32'h0000_0110);
    cfgCheck(4, 32'h0000_0210, "R3 commit handshake");
    cfgWrite(4, 32'h0000_0010);
    cfgCheck(4, 32'h0000_0210, "R4 committed kept");

    sendExp(0, B + 64'h1234, 1, 0, 64'h934, "R8 read translate");
    sendExp(1, B + 64'h1234, 1, 0, 64'h934, "R8 write translate");
    sendExp(0, B - 64'd1, 0, 1, 0, "R6 read below base");
    sendExp(1, B - 64'd1, 0, 0, 0, "R10 write below base");
    sendExp(0, B + 64'h1FFF_FFFF, 1, 0, 64'h0FFF_FFFF, "R7 last offset");
    sendExp(0, B + 64'h2000_0000, 0, 1, 0, "R7 offset equals size");
    sendExp(1, B + 64'h2000_0000, 0, 0, 0, "R10 write past end");
    idle(2);

    // R8: width 2, chunk 2
    cfgWrite(4, 32'h0000_0122);
    sendExp(0, B + 64'hABCD, 1, 0, 64'h2BCD, "R8 width2 chunk2");
    idle(1);

    // R9: no interleave, capacity bound
    cfgWrite(4, 32'h0000_0100);
    sendExp(0, B + 64'h1000_0000, 0, 1, 0, "R9 read beyond capacity");
    sendExp(1, B + 64'h1000_0000, 0, 0, 0, "R9 write beyond capacity");
    sendExp(0, B + 64'h0FFF_FFF0, 1, 0, 64'h0FFF_FFF0, "R9 read below capacity");
    idle(1);

    // R8/R11: back-to-back sweep, width 3, chunk 1
    cfgWrite(4, 32'h0000_0131);
    for (int i = 0; i < 16; i++)
      sendModel(i[0], B + 64'(i) * 64'h0123_4567 - 64'h100, "R8 sweep");
    idle(3);

    chk("R11 scoreboard drained", 64'(q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule